// File: doc/BRIEF.md
# Reciprocal Period and Duty Meter

This block times a digital input against the system clock. After synchronizing the input, it counts clock ticks between successive rising edges to get the period, and it latches the count at the falling edge between them to get the high time. The result resolves to one clock tick. Software turns the counts into frequency or duty ratio.

Two configuration fields extend its use. A ratio select makes the block count only every 2^d-th rising edge, so fast inputs still give usable counts. An averaging select sums 2^k consecutive periods and high times and shifts the sums right by k before reporting. Each finished group is reported with a one-cycle strobe. If an armed measurement runs the counter to its ceiling with no new edge, the block raises a timeout pulse and waits for a fresh starting edge. The configuration fields may only change while `en` is low.

Top module: `pulse_span_meter`

## Requirements
- R1: With ratio select 0 and averaging select 0, `period_avg` equals the number of clock cycles between two successive rising edges of `sig_in`, and it is reported with a `result_valid` pulse.
- R2: With ratio select 0, `high_avg` equals the number of clock cycles from a counted rising edge to the following falling edge, `duty_valid` pulses together with `result_valid`, and `high_avg` never exceeds `period_avg`.
- R3: The first counted rising edge after `en` rises, or after a timeout, only starts timing and produces no result.
- R4: Averaging select k (0..3) sums 2^k consecutive periods and high times, reports each sum shifted right by k, and gives one result per group of 2^k periods.
- R5: Ratio select d (0..3) counts only every 2^d-th rising edge, so the reported period spans 2^d input periods.
- R6: When ratio select is nonzero, `duty_valid` stays low and `high_avg` reads 0 on every result.
- R7: If a started measurement reaches 2^CNT_W-1 counts without a counted rising edge, `timeout` pulses for one cycle, no result is given, and the next counted edge starts a new measurement. A counted edge that arrives exactly at the count 2^CNT_W-1 is reported as a period of 2^CNT_W-1 and raises no timeout.
- R8: While `en` is low, all partial sums are discarded, and neither `result_valid` nor `timeout` is high in the cycle after `en` was low.
- R9: After reset, all outputs are 0.
- R10: `result_valid` and `timeout` are never high in the same cycle, and `result_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick is the unit of measurement |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Measurement enable; low clears all progress |
| sig_in | input | 1 | Asynchronous input being measured |
| cfg_div_sel | input | 2 | Edge ratio select d; 2^d rising edges per counted edge |
| cfg_avg_sel | input | 2 | Averaging select k; 2^k periods per result |
| period_avg | output | CNT_W | Averaged period in clock ticks |
| high_avg | output | CNT_W | Averaged high time in clock ticks (0 when the ratio is not 1) |
| result_valid | output | 1 | One-cycle strobe for new output values |
| duty_valid | output | 1 | High with `result_valid` when `high_avg` is meaningful |
| timeout | output | 1 | One-cycle pulse when the counter saturates without an edge |

## Verification
The two functions that can land in the same cycle are the arrival of a counted rising edge and counter saturation. This happens when the edge comes exactly 2^CNT_W-1 ticks after the previous one. The bench builds the block with a narrow counter and spaces two rising edges exactly that far apart, which must give a period of the ceiling value and no timeout. It then spaces them one tick further apart, which must give a timeout followed by a fresh start and no result. A cycle-accurate behavioural model in the bench checks every strobe and output value on every clock during these cases.

// File: rtl/psm_pkg.sv
package psm_pkg;

    // width of each configuration select field
    localparam int SEL_W = 2;
    // largest shift / prescale count the selects can ask for (2^SEL_W - 1)
    localparam int EXT_W = (1 << SEL_W) - 1;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } meter_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    // low-bit mask for a power-of-two count chosen by a select field
    function automatic logic [EXT_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
        return EXT_W'((1 << s) - 1);
    endfunction

endpackage

// File: rtl/psm_sync_edge.sv
module psm_sync_edge
    import psm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output edge_ev_t ev
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], din};
            last  <= chain[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ev.rise = chain[SYNC_STAGES-1] & ~last;
        ev.fall = ~chain[SYNC_STAGES-1] & last;
    end
endmodule

// File: rtl/psm_prescale.sv
module psm_prescale
    import psm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  edge_ev_t         ev,
    input  logic [SEL_W-1:0] div_sel,
    output logic             mark,
    output logic             fall_ev
);
    logic [EXT_W-1:0] pcnt;
    logic [EXT_W-1:0] mask;

    always_comb begin
        mask    = sel_mask(div_sel);
        mark    = en & ev.rise & ((pcnt & mask) == '0);
        fall_ev = en & ev.fall & (div_sel == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pcnt <= '0;
        end else if (ev.rise) begin
            pcnt <= (pcnt + 1'b1) & mask;
        end
    end
endmodule

// File: rtl/psm_span_counter.sv
module psm_span_counter
    import psm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mark,
    input  logic             fall_ev,
    input  logic [SEL_W-1:0] avg_sel,
    input  logic [SEL_W-1:0] div_sel,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] high_o,
    output logic             result_o,
    output logic             duty_o,
    output logic             timeout_o
);
    localparam int ACC_W = CNT_W + EXT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meter_state_e     state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] high_cap;
    logic [ACC_W-1:0] acc_p, acc_h, sum_p, sum_h;
    logic [CNT_W-1:0] avg_p, avg_h;
    logic [EXT_W-1:0] n_done;
    logic             group_full;
    logic             duty_ok;

    always_comb begin
        sum_p      = acc_p + ACC_W'(cnt);
        sum_h      = acc_h + ACC_W'(high_cap);
        avg_p      = CNT_W'(sum_p >> avg_sel);
        avg_h      = CNT_W'(sum_h >> avg_sel);
        group_full = (n_done == sel_mask(avg_sel));
        duty_ok    = (div_sel == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAIT;
            cnt       <= '0;
            high_cap  <= '0;
            acc_p     <= '0;
            acc_h     <= '0;
            n_done    <= '0;
            period_o  <= '0;
            high_o    <= '0;
            result_o  <= 1'b0;
            duty_o    <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            result_o  <= 1'b0;
            duty_o    <= 1'b0;
            timeout_o <= 1'b0;
            if (!en) begin
                state    <= ST_WAIT;
                cnt      <= '0;
                high_cap <= '0;
                acc_p    <= '0;
                acc_h    <= '0;
                n_done   <= '0;
            end else if (state == ST_WAIT) begin
                if (mark) begin
                    state    <= ST_RUN;
                    cnt      <= CNT_W'(1);
                    high_cap <= '0;
                    acc_p    <= '0;
                    acc_h    <= '0;
                    n_done   <= '0;
                end
            end else if (mark) begin
                // an edge wins over saturation in the same cycle
                cnt      <= CNT_W'(1);
                high_cap <= '0;
                if (group_full) begin
                    result_o <= 1'b1;
                    duty_o   <= duty_ok;
                    period_o <= avg_p;
                    high_o   <= duty_ok ? avg_h : '0;
                    acc_p    <= '0;
                    acc_h    <= '0;
                    n_done   <= '0;
                end else begin
                    acc_p  <= sum_p;
                    acc_h  <= sum_h;
                    n_done <= n_done + 1'b1;
                end
            end else if (cnt == CNT_MAX) begin
                timeout_o <= 1'b1;
                state     <= ST_WAIT;
                cnt       <= '0;
                high_cap  <= '0;
                acc_p     <= '0;
                acc_h     <= '0;
                n_done    <= '0;
            end else begin
                if (fall_ev) begin
                    high_cap <= cnt;
                end
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pulse_span_meter.sv
module pulse_span_meter
    import psm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             sig_in,
    input  logic [1:0]       cfg_div_sel,
    input  logic [1:0]       cfg_avg_sel,
    output logic [CNT_W-1:0] period_avg,
    output logic [CNT_W-1:0] high_avg,
    output logic             result_valid,
    output logic             duty_valid,
    output logic             timeout
);
    edge_ev_t ev;
    logic     mark;
    logic     fall_ev;

    psm_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (sig_in),
        .ev  (ev)
    );

    psm_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ev      (ev),
        .div_sel (cfg_div_sel),
        .mark    (mark),
        .fall_ev (fall_ev)
    );

    psm_span_counter #(.CNT_W(CNT_W)) u_span (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mark      (mark),
        .fall_ev   (fall_ev),
        .avg_sel   (cfg_avg_sel),
        .div_sel   (cfg_div_sel),
        .period_o  (period_avg),
        .high_o    (high_avg),
        .result_o  (result_valid),
        .duty_o    (duty_valid),
        .timeout_o (timeout)
    );
endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [1:0]       cfg_div_sel,
    input logic [CNT_W-1:0] period_avg,
    input logic [CNT_W-1:0] high_avg,
    input logic             result_valid,
    input logic             duty_valid,
    input logic             timeout
);
    a_r10_no_collide: assert property (@(posedge clk) disable iff (rst)
        !(result_valid && timeout));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!result_valid && !timeout));

    a_r2_duty_with_result: assert property (@(posedge clk) disable iff (rst)
        duty_valid |-> result_valid);

    a_r2_high_within_period: assert property (@(posedge clk) disable iff (rst)
        duty_valid |-> (high_avg <= period_avg));

    a_r6_duty_gated: assert property (@(posedge clk) disable iff (rst)
        (result_valid && $past(cfg_div_sel) != 2'd0) |-> (!duty_valid && high_avg == '0));
endmodule

bind pulse_span_meter psm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .cfg_div_sel  (cfg_div_sel),
    .period_avg   (period_avg),
    .high_avg     (high_avg),
    .result_valid (result_valid),
    .duty_valid   (duty_valid),
    .timeout      (timeout)
);

// File: tb/sim_pulse_span_meter.sv
`timescale 1ns/1ps
module sim_pulse_span_meter;
    localparam int CW   = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          sig_in = 1'b0;
    logic [1:0]    cfg_div_sel = 2'd0;
    logic [1:0]    cfg_avg_sel = 2'd0;
    logic [CW-1:0] period_avg, high_avg;
    logic          result_valid, duty_valid, timeout;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pulse_span_meter #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .en(en), .sig_in(sig_in),
        .cfg_div_sel(cfg_div_sel), .cfg_avg_sel(cfg_avg_sel),
        .period_avg(period_avg), .high_avg(high_avg),
        .result_valid(result_valid), .duty_valid(duty_valid), .timeout(timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: delay line, edge ratio, tick timing, averaging
    int q1, q2, q3, m_pc, m_arm, m_cnt, m_high, m_ap, m_ah, m_n;
    int e_pv, e_dv, e_to, e_p, e_h;
    always @(posedge clk) begin
        if (rst) begin
            q1 = 0; q2 = 0; q3 = 0; m_pc = 0; m_arm = 0; m_cnt = 0; m_high = 0;
            m_ap = 0; m_ah = 0; m_n = 0; e_pv = 0; e_dv = 0; e_to = 0; e_p = 0; e_h = 0;
        end else begin
            int rise, fall, mark, fv, dm, na;
            rise = (q2 == 1 && q3 == 0);
            fall = (q2 == 0 && q3 == 1);
            q3 = q2; q2 = q1; q1 = sig_in;
            dm = 1 << cfg_div_sel;
            na = 1 << cfg_avg_sel;
            mark = en && rise && (m_pc == 0);
            if (!en) m_pc = 0;
            else if (rise) m_pc = (m_pc + 1) % dm;
            fv = en && fall && (cfg_div_sel == 0);
            e_pv = 0; e_dv = 0; e_to = 0;
            if (!en) begin
                m_arm = 0; m_cnt = 0; m_high = 0; m_ap = 0; m_ah = 0; m_n = 0;
            end else if (!m_arm) begin
                if (mark) begin
                    m_arm = 1; m_cnt = 1; m_high = 0; m_ap = 0; m_ah = 0; m_n = 0;
                end
            end else if (mark) begin
                m_ap += m_cnt; m_ah += m_high; m_n++;
                if (m_n == na) begin
                    e_pv = 1;
                    e_dv = (cfg_div_sel == 0);
                    e_p  = m_ap / na;
                    e_h  = (cfg_div_sel == 0) ? m_ah / na : 0;
                    m_ap = 0; m_ah = 0; m_n = 0;
                end
                m_cnt = 1; m_high = 0;
            end else if (m_cnt == CMAX) begin
                e_to = 1; m_arm = 0; m_cnt = 0; m_high = 0; m_ap = 0; m_ah = 0; m_n = 0;
            end else begin
                if (fv) m_high = m_cnt;
                m_cnt++;
            end
        end
    end

    // per-cycle comparison plus event bookkeeping for directed checks
    int n_res = 0, n_to = 0, last_p = 0, last_h = 0, last_d = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1/R4/R5 period_avg", int'(period_avg), e_p);
            chk("R2/R6 high_avg", int'(high_avg), e_h);
            chk("R3/R10 result_valid", int'(result_valid), e_pv);
            chk("R2/R6 duty_valid", int'(duty_valid), e_dv);
            chk("R7 timeout", int'(timeout), e_to);
            if (result_valid) begin
                n_res++; last_p = period_avg; last_h = high_avg; last_d = duty_valid;
            end
            if (timeout) n_to++;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        sig_in = 1'b1; wait_n(hi);
        sig_in = 1'b0; wait_n(lo);
    endtask

    task automatic start(input int dsel, input int asel);
        en = 1'b0; wait_n(2);
        cfg_div_sel = 2'(dsel); cfg_avg_sel = 2'(asel);
        n_res = 0; n_to = 0;
        wait_n(1); en = 1'b1; wait_n(2);
    endtask

    task automatic settle;
        wait_n(6); #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        wait_n(4); #1;
        chk("R9 reset period_avg", int'(period_avg), 0);
        chk("R9 reset high_avg", int'(high_avg), 0);
        chk("R9 reset strobes", int'({result_valid, duty_valid, timeout}), 0);
        @(negedge clk); rst = 1'b0;

        // plain period and high time; first edge only arms
        start(0, 0);
        for (int i = 0; i < 6; i++) pulse(7, 13);
        settle();
        chk("R3 result count for 6 edges", n_res, 5);
        chk("R1 period", last_p, 20);
        chk("R2 high time", last_h, 7);
        chk("R2 duty_valid", last_d, 1);

        // averaging over four unequal periods
        start(0, 2);
        pulse(5, 15); pulse(5, 16); pulse(5, 17); pulse(5, 18); pulse(5, 15);
        settle();
        chk("R4 one result per group", n_res, 1);
        chk("R4 averaged period", last_p, 21);
        chk("R4 averaged high", last_h, 5);

        // edge ratio of two
        start(1, 0);
        for (int i = 0; i < 7; i++) pulse(4, 6);
        settle();
        chk("R5 result count", n_res, 3);
        chk("R5 period spans two inputs", last_p, 20);
        chk("R6 high reads zero", last_h, 0);
        chk("R6 duty_valid low", last_d, 0);

        // plain timeout
        start(0, 0);
        pulse(3, 1100);
        #1;
        chk("R7 timeout count", n_to, 1);
        chk("R7 no result on timeout", n_res, 0);

        // edge exactly at the ceiling count: result, no timeout
        start(0, 0);
        pulse(3, CMAX - 3); pulse(3, 5);
        settle();
        chk("R7 ceiling period reported", last_p, CMAX);
        chk("R7 ceiling edge result count", n_res, 1);
        chk("R7 ceiling edge no timeout", n_to, 0);

        // one tick past the ceiling: timeout then a fresh start
        start(0, 0);
        pulse(3, CMAX - 2); pulse(3, 5);
        settle();
        chk("R7 late edge timeout", n_to, 1);
        chk("R3 late edge only restarts", n_res, 0);

        // enable drop discards partial sums
        start(0, 3);
        for (int i = 0; i < 5; i++) pulse(10, 20);
        en = 1'b0; wait_n(3); en = 1'b1; wait_n(2);
        for (int i = 0; i < 9; i++) pulse(4, 8);
        settle();
        chk("R8 result after re-enable", n_res, 1);
        chk("R8 stale periods discarded", last_p, 12);
        chk("R8 stale highs discarded", last_h, 4);

        en = 1'b0; wait_n(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule